// File: doc/BRIEF.md
# Lane Register Shuffle Network

This block lets a group of lanes trade register values with one another in one pass, with no memory involved. A request carries one value per lane, a participation mask, an operation code, a lane-or-distance operand and a sub-group size. Each lane gets one value back, taken either from another lane or from itself. The lanes are cut into aligned sub-groups whose size is a power of two, and no lane ever reads across the edge of its own sub-group.

There are four operations. The first is an indexed read, which broadcasts one lane of each sub-group to every lane in it. The second and third move values a fixed distance toward higher or lower lane numbers. The fourth is a butterfly exchange that pairs each lane with the lane whose index differs from it by an XOR mask. A lane that sits outside the mask, or whose source would fall outside its sub-group, keeps its own value.

Requests enter on a valid/ready port and results leave on a second valid/ready port, one register stage later. Both follow the usual rule: a word moves on a clock edge at which valid and ready are both high. The input accepts a request whenever the output register is empty or is being drained on that same edge. While the output is stalled, the result it holds does not change. Valid never waits on ready.

Top module: `warp_shuffle_net`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, out_valid is 0 and in_ready is 1.
- R2: in_ready equals (not out_valid) or out_ready. A request accepted at one edge appears on out_valid/out_lanes after that edge. While out_valid is 1 and out_ready is 0, out_lanes stays unchanged and out_valid stays 1.
- R3: in_wsel gives the sub-group size as 2^in_wsel. Any value above log2(LANES) means the full lane count. Sub-groups are aligned: lane i belongs to the group that starts at lane i rounded down to a multiple of the size W.
- R4: When in_op = 0 (indexed read), an active lane i returns the input of lane base(i) + (in_operand mod W). With W = LANES and source 0, every active lane receives lane 0's value.
- R5: When in_op = 1 (shift up), an active lane i returns lane i - in_operand if that lane is in the same sub-group. Otherwise it returns its own value.
- R6: When in_op = 2 (shift down), an active lane i returns lane i + in_operand if that lane is in the same sub-group. Otherwise it returns its own value. For distance 2, size 8 and lane inputs equal to lane numbers, each group of eight gives 2,3,4,5,6,7,6,7.
- R7: When in_op = 3 (butterfly), an active lane i returns lane i XOR in_operand if that lane is in the same sub-group. Otherwise it returns its own value.
- R8: A lane whose bit in in_mask is 0 returns its own input value, whatever the operation.
- R9: A lane that is read as a source gives its input value whether or not its own mask bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | The block takes the request at this edge |
| in_lanes | input | LANES*DATA_W | Lane values, lane i at bits [i*DATA_W +: DATA_W] |
| in_mask | input | LANES | Participation mask, bit i for lane i |
| in_op | input | 2 | 0 indexed, 1 up, 2 down, 3 butterfly |
| in_operand | input | log2(LANES) | Source lane, distance or XOR mask |
| in_wsel | input | clog2(log2(LANES)+1) | log2 of the sub-group size |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | The consumer takes the result at this edge |
| out_lanes | output | LANES*DATA_W | Result values, same packing as in_lanes |

## Verification
Two things can happen on one edge: the result register hands off the word it holds, and it takes in a new request. The bench provokes this by keeping in_valid high without gaps while a pseudo-random out_ready stream mixes drain-and-refill edges with stalls. Each result is compared, in order, against a queue of values computed arithmetically from the lane, group and operand rules. Any lost or repeated word shows up as a mismatch. The value held during each stall must also come out unchanged on the next cycle.

// File: rtl/shfl_pkg.sv
package shfl_pkg;

  typedef enum logic [1:0] {
    SHFL_IDX  = 2'd0,
    SHFL_UP   = 2'd1,
    SHFL_DOWN = 2'd2,
    SHFL_XOR  = 2'd3
  } shfl_op_e;

endpackage

// File: rtl/shfl_src_sel.sv
// Per-lane source index computation: one small adder/compare slice per lane.
module shfl_src_sel
  import shfl_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int LANE_W = $clog2(LANES),
  parameter int WSEL_W = $clog2(LANE_W + 1)
) (
  input  shfl_op_e                        op,
  input  logic [LANE_W-1:0]               operand,
  input  logic [WSEL_W-1:0]               wsel,
  input  logic [LANES-1:0]                mask,
  output logic [LANES-1:0][LANE_W-1:0]    src
);

  localparam logic [LANE_W:0] ONE = (LANE_W + 1)'(1);

  logic [LANE_W:0]   wsize;
  logic [LANE_W-1:0] low;

  // Sub-group size, clamped to the full lane count (R3).
  always_comb begin
    if (wsel >= WSEL_W'(LANE_W)) wsize = ONE << LANE_W;
    else                         wsize = ONE << wsel;
    low = LANE_W'(wsize - ONE);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LANE_W-1:0] ME = LANE_W'(g);

    logic [LANE_W-1:0] base, off, xr, sel;
    logic [LANE_W:0]   dsum;
    logic              up_ok, dn_ok, xr_ok;

    always_comb begin
      base  = ME & ~low;
      off   = ME & low;
      dsum  = {1'b0, off} + {1'b0, operand};
      up_ok = (off >= operand);                  // R5: stays above group start
      dn_ok = (dsum < wsize);                    // R6: stays below group end
      xr    = ME ^ operand;
      xr_ok = ((operand & ~low) == '0);          // R7: flips only in-group bits
      sel   = ME;                                // R8 default: own value
      if (mask[g]) begin
        unique case (op)
          SHFL_IDX:  sel = base | (operand & low);
          SHFL_UP:   if (up_ok) sel = ME - operand;
          SHFL_DOWN: if (dn_ok) sel = ME + operand;
          SHFL_XOR:  if (xr_ok) sel = xr;
          default:   sel = ME;
        endcase
      end
    end

    assign src[g] = sel;
  end

endmodule

// File: rtl/shfl_xbar.sv
// Full crossbar: every output lane picks one input lane by index.
module shfl_xbar #(
  parameter int LANES  = 32,
  parameter int DATA_W = 32,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic [LANES-1:0][DATA_W-1:0] din,
  input  logic [LANES-1:0][LANE_W-1:0] src,
  output logic [LANES-1:0][DATA_W-1:0] dout
);

  for (genvar g = 0; g < LANES; g++) begin : g_mux
    assign dout[g] = din[src[g]];             // R9: source mask bit not consulted
  end

endmodule

// File: rtl/shfl_out_stage.sv
// One-entry output register with pass-through ready.
module shfl_out_stage #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

endmodule

// File: rtl/warp_shuffle_net.sv
module warp_shuffle_net
  import shfl_pkg::*;
#(
  parameter  int LANES  = 32,
  parameter  int DATA_W = 32,
  localparam int LANE_W = $clog2(LANES),
  localparam int WSEL_W = $clog2(LANE_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*DATA_W-1:0] in_lanes,
  input  logic [LANES-1:0]        in_mask,
  input  logic [1:0]              in_op,
  input  logic [LANE_W-1:0]       in_operand,
  input  logic [WSEL_W-1:0]       in_wsel,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*DATA_W-1:0] out_lanes
);

  shfl_op_e                        op_e;
  logic [LANES-1:0][DATA_W-1:0]    din;
  logic [LANES-1:0][DATA_W-1:0]    dshuf;
  logic [LANES-1:0][LANE_W-1:0]    src;

  assign op_e = shfl_op_e'(in_op);
  assign din  = in_lanes;

  shfl_src_sel #(
    .LANES (LANES),
    .LANE_W(LANE_W),
    .WSEL_W(WSEL_W)
  ) src_sel_i (
    .op     (op_e),
    .operand(in_operand),
    .wsel   (in_wsel),
    .mask   (in_mask),
    .src    (src)
  );

  shfl_xbar #(
    .LANES (LANES),
    .DATA_W(DATA_W),
    .LANE_W(LANE_W)
  ) xbar_i (
    .din (din),
    .src (src),
    .dout(dshuf)
  );

  shfl_out_stage #(
    .WIDTH(LANES * DATA_W)
  ) out_stage_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (dshuf),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_lanes)
  );

  // Group boundary seen independently of the selector, for the checks below.
  logic [LANE_W-1:0] grp_hi;
  always_comb begin
    if (in_wsel >= WSEL_W'(LANE_W)) grp_hi = '0;
    else                            grp_hi = {LANE_W{1'b1}} << in_wsel;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    p_in_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ((src[g] & grp_hi) == (LANE_W'(g) & grp_hi)));

    p_masked_own_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !in_mask[g]
      |=> out_lanes[g*DATA_W +: DATA_W] == $past(din[g]));

    p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_mask[g] && (in_op == 2'd0) &&
      (in_wsel >= WSEL_W'(LANE_W))
      |=> out_lanes[g*DATA_W +: DATA_W] == $past(din[in_operand]));
  end

endmodule

// File: tb/warp_shuffle_net_tb_top.sv
module warp_shuffle_net_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int L      = 32;
  localparam int DW     = 16;
  localparam int LW     = $clog2(L);
  localparam int WSW    = $clog2(LW + 1);
  localparam int NSWEEP = 4 * 8 * L;
  localparam int TOTAL  = 2 + NSWEEP;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [L*DW-1:0] in_lanes = '0;
  logic [L-1:0]    in_mask = '0;
  logic [1:0]      in_op = '0;
  logic [LW-1:0]   in_operand = '0;
  logic [WSW-1:0]  in_wsel = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [L*DW-1:0] out_lanes;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  warp_shuffle_net #(.LANES(L), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_lanes(in_lanes),
    .in_mask(in_mask), .in_op(in_op), .in_operand(in_operand), .in_wsel(in_wsel),
    .out_valid(out_valid), .out_ready(out_ready), .out_lanes(out_lanes)
  );

  // Reference: lane/group arithmetic from the requirements.
  function automatic logic [L*DW-1:0] model(input logic [L*DW-1:0] d, input logic [L-1:0] m,
                                            input int op, input int opd, input int wl);
    logic [L*DW-1:0] r;
    int w;
    w = (wl > LW) ? L : (1 << wl);
    for (int i = 0; i < L; i++) begin
      int s, grp, off, t;
      s = i; grp = i / w; off = i % w;
      if (m[i]) begin
        case (op)
          0: s = grp * w + (opd % w);
          1: if (off - opd >= 0) s = i - opd;
          2: if (off + opd < w) s = i + opd;
          default: begin t = i ^ opd; if (t / w == grp) s = t; end
        endcase
      end
      r[i*DW +: DW] = d[s*DW +: DW];
    end
    return r;
  endfunction

  task automatic load(input int n);
    int op, wl, opd;
    logic [L-1:0] m;
    for (int i = 0; i < L; i++) in_lanes[i*DW +: DW] = DW'(((n & 255) << 8) | i);
    if (n == 0) begin op = 2; wl = 3; opd = 2; m = '1; end        // R6 stated case
    else if (n == 1) begin op = 0; wl = LW; opd = 0; m = '1; end  // R4 broadcast
    else begin
      int k;
      k = n - 2;
      op = k / 256; wl = (k / 32) % 8; opd = k % 32;
      case (k % 4)
        0, 1: m = '1;
        2:    m = 32'h6DB6_DB6D ^ L'(k);
        default: m = ~(L'(1) << (k % L));
      endcase
    end
    in_op = 2'(op); in_wsel = WSW'(wl); in_operand = LW'(opd); in_mask = m;
    in_valid = 1'b1;
  endtask

  function automatic string tag_of(input int op, input int wl, input logic [L-1:0] m);
    string s;
    case (op)
      0: s = "R4";
      1: s = "R5";
      2: s = "R6";
      default: s = "R7";
    endcase
    if (wl > LW) s = {s, " R3"};
    if (m != '1) s = {s, " R8 R9"};
    return s;
  endfunction

  logic [L*DW-1:0] exp_q[$];
  string           tag_q[$];
  int              id_q[$];

  initial begin
    int n, got, cyc;
    logic [15:0] lfsr;
    bit stall_prev, acc_prev, fire_in;
    logic [L*DW-1:0] stall_data;
    n = 0; got = 0; cyc = 0; lfsr = 16'hACE1;
    stall_prev = 0; acc_prev = 0; stall_data = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 in reset: out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;
    load(0);

    while (got < TOTAL) begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (cyc < 40) ? 1'b1 : (lfsr[0] | lfsr[3]);
      #1;
      if (cyc == 1) begin
        checks++;
        if (out_valid !== 1'b0) begin
          errors++;
          $display("FAIL R1 after reset: out_valid=%b expected 0", out_valid);
        end
      end
      checks++;
      if (in_ready !== (!out_valid || out_ready)) begin
        errors++;
        $display("FAIL R2 in_ready=%b expected %b", in_ready, (!out_valid || out_ready));
      end
      if (acc_prev) begin
        checks++;
        if (out_valid !== 1'b1) begin
          errors++;
          $display("FAIL R2 latency: out_valid=%b expected 1", out_valid);
        end
      end
      if (stall_prev) begin
        checks++;
        if (out_valid !== 1'b1 || out_lanes !== stall_data) begin
          errors++;
          $display("FAIL R2 stall hold: out=%h expected %h", out_lanes, stall_data);
        end
      end
      if (out_valid && out_ready && exp_q.size() > 0) begin
        logic [L*DW-1:0] e;
        string t;
        int id;
        e = exp_q.pop_front(); t = tag_q.pop_front(); id = id_q.pop_front();
        checks++;
        if (out_lanes !== e) begin
          errors++;
          $display("FAIL %s txn %0d actual %h expected %h", t, id, out_lanes, e);
        end
        got++;
      end
      stall_prev = out_valid && !out_ready;
      stall_data = out_lanes;
      fire_in = in_valid && in_ready;
      acc_prev = fire_in;
      if (fire_in) begin
        exp_q.push_back(model(in_lanes, in_mask, int'(in_op), int'(in_operand), int'(in_wsel)));
        tag_q.push_back(tag_of(int'(in_op), int'(in_wsel), in_mask));
        id_q.push_back(n);
      end
      @(posedge clk); #1;
      if (fire_in) begin
        n++;
        if (n < TOTAL) load(n);
        else in_valid = 1'b0;
      end
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, R2 flow stalled");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule